// File: doc/BRIEF.md
# Address-Stream Context Packet Decoder

This block sits beside a memory device and watches the request stream without taking part in it. Software hides small pieces of context in the addresses of ordinary reads aimed at a reserved 4 MiB mailbox window. The data there is ordinary application data, and its values are never used. The decoder spots those reads. It turns the line offset of each one into a 16-bit packet, and it frames the packets into messages.

A message is a marked header carrying the core ID, followed by two payload packets: the function ID and then the loop-iteration value. Each finished message is presented as one record on a valid/ready output.

Packets from different requesting sources can interleave. The decoder therefore keeps a separate framing state for each source index. Three counters record stray payloads, abandoned messages and records lost to a full output.

Top module: `ctxpkt_decoder`

## Requirements
- R1: A request is decoded only when `req_valid` is 1, `req_is_read` is 1 and `req_addr[31:22]` equals bits 31:22 of the 4 MiB-aligned parameter `WIN_BASE` (default 0x4000_0000). Any other address is ignored.
- R2: The packet of a decoded request is `req_addr[21:6]`. Address bits 5:0 have no effect.
- R3: For one source, a header (packet bits 15:12 equal 0xC, core ID in bits 11:0), then a function-ID packet, then an iteration packet produce one record. The record appears on `rec_valid`/`rec_core`/`rec_func`/`rec_iter` after the second rising edge following the sampling of the iteration request.
- R4: Write requests never change framing state, counters or the output, including writes that hit the window.
- R5: A non-header packet arriving at a source that is waiting for a header is dropped and increments `err_count` by one.
- R6: A header arriving while a source is waiting for a payload discards the partial message and increments `abort_count` by one. Framing restarts from the new header.
- R7: Each value of `req_src` has its own framing state, so interleaved messages from different sources complete independently and correctly.
- R8: A record is held, stable, while `rec_valid` is 1 and `rec_ready` is 0. It is consumed on a rising edge where both are 1.
- R9: A record that completes while the output holds an unconsumed record, with `rec_ready` at 0, is dropped and increments `ovf_count` by one. The held record is kept.
- R10: Synchronous reset clears `rec_valid` and all counters and returns every source to waiting for a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Observed request is valid |
| req_is_read | input | 1 | 1 for read, 0 for write |
| req_src | input | SRC_W (2) | Requesting source index |
| req_addr | input | ADDR_W (32) | Physical request address |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_valid | output | 1 | Record available |
| rec_core | output | 12 | Core ID from the header |
| rec_func | output | 16 | Function ID |
| rec_iter | output | 16 | Loop-iteration value |
| err_count | output | CNT_W (16) | Stray-payload count |
| abort_count | output | CNT_W (16) | Abandoned-message count |
| ovf_count | output | CNT_W (16) | Records dropped on a full output |

## Verification
The hardest situation to reach from the ports is two sources holding partial messages at the same time, with one of them also aborted or overflowed. The stimulus brings this about by interleaving headers and payloads of two source indices in one burst. It then completes the later-started message first and leaves the other pending across a consume.

Overflow is reached by finishing a second message while `rec_ready` is held low. The record still shown is then checked against the first message.

Write-only messages are followed by bare read payloads. Had the writes been framed, those payloads would have completed a record. Because they were not, they must instead raise the error count.

// File: rtl/ctxpkt_pkg.sv
package ctxpkt_pkg;
  localparam int PKT_W    = 16;
  localparam int CORE_W   = 12;
  localparam int WIN_LSB  = 22;
  localparam int LINE_LSB = 6;
  localparam logic [3:0] HDR_MARK = 4'hC;

  typedef enum logic [1:0] {
    FR_IDLE      = 2'd0,
    FR_WAIT_FUNC = 2'd1,
    FR_WAIT_ITER = 2'd2
  } frame_st_e;

  typedef struct packed {
    logic [CORE_W-1:0] core;
    logic [PKT_W-1:0]  func;
    logic [PKT_W-1:0]  iter;
  } ctx_rec_t;
endpackage

// File: rtl/ctxpkt_window_match.sv
module ctxpkt_window_match
  import ctxpkt_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h4000_0000,
  parameter int                SRC_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_is_read,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              pkt_v,
  output logic [PKT_W-1:0]  pkt,
  output logic [SRC_W-1:0]  pkt_src
);
  logic in_window;
  logic unused_line_bits;

  assign in_window        = (req_addr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB]);
  assign unused_line_bits = ^req_addr[LINE_LSB-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_v   <= 1'b0;
      pkt     <= '0;
      pkt_src <= '0;
    end else begin
      pkt_v   <= req_valid && req_is_read && in_window;
      pkt     <= req_addr[WIN_LSB-1:LINE_LSB];
      pkt_src <= req_src;
    end
  end
endmodule

// File: rtl/ctxpkt_framer.sv
module ctxpkt_framer
  import ctxpkt_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int SRC_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pkt_v,
  input  logic [PKT_W-1:0] pkt,
  input  logic [SRC_W-1:0] pkt_src,
  output logic             rec_done,
  output ctx_rec_t         rec_d,
  output logic             frame_err,
  output logic             frame_abort
);
  logic                  is_hdr;
  logic [NUM_CORES-1:0]  done_s;
  logic [NUM_CORES-1:0]  err_s;
  logic [NUM_CORES-1:0]  abort_s;
  logic [CORE_W-1:0]     core_a [NUM_CORES];
  logic [PKT_W-1:0]      func_a [NUM_CORES];

  assign is_hdr = (pkt[PKT_W-1:PKT_W-4] == HDR_MARK);

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_slot
    frame_st_e         st_q;
    logic [CORE_W-1:0] core_q;
    logic [PKT_W-1:0]  func_q;
    logic              hit;

    assign hit = pkt_v && (pkt_src == SRC_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        st_q   <= FR_IDLE;
        core_q <= '0;
        func_q <= '0;
      end else if (hit) begin
        if (is_hdr) begin
          st_q   <= FR_WAIT_FUNC;
          core_q <= pkt[CORE_W-1:0];
        end else begin
          case (st_q)
            FR_WAIT_FUNC: begin
              func_q <= pkt;
              st_q   <= FR_WAIT_ITER;
            end
            FR_WAIT_ITER: st_q <= FR_IDLE;
            default:      st_q <= FR_IDLE;
          endcase
        end
      end
    end

    assign done_s[i]  = hit && !is_hdr && (st_q == FR_WAIT_ITER);
    assign err_s[i]   = hit && !is_hdr && (st_q == FR_IDLE);
    assign abort_s[i] = hit && is_hdr && (st_q != FR_IDLE);
    assign core_a[i]  = core_q;
    assign func_a[i]  = func_q;
  end

  assign rec_done    = |done_s;
  assign frame_err   = |err_s;
  assign frame_abort = |abort_s;

  always_comb begin
    rec_d.core = core_a[pkt_src];
    rec_d.func = func_a[pkt_src];
    rec_d.iter = pkt;
  end
endmodule

// File: rtl/ctxpkt_out_reg.sv
module ctxpkt_out_reg
  import ctxpkt_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  ctx_rec_t load_rec,
  input  logic     ready,
  output logic     valid,
  output ctx_rec_t rec,
  output logic     drop
);
  assign drop = load && valid && !ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      rec   <= '0;
    end else if (load && (!valid || ready)) begin
      valid <= 1'b1;
      rec   <= load_rec;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ctxpkt_event_ctr.sv
module ctxpkt_event_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/ctxpkt_decoder.sv
module ctxpkt_decoder
  import ctxpkt_pkg::*;
#(
  parameter int                NUM_CORES = 4,
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h4000_0000,
  parameter int                CNT_W     = 16,
  localparam int               SRC_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_is_read,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              rec_ready,
  output logic              rec_valid,
  output logic [CORE_W-1:0] rec_core,
  output logic [PKT_W-1:0]  rec_func,
  output logic [PKT_W-1:0]  rec_iter,
  output logic [CNT_W-1:0]  err_count,
  output logic [CNT_W-1:0]  abort_count,
  output logic [CNT_W-1:0]  ovf_count
);
  logic             pkt_v;
  logic [PKT_W-1:0] pkt;
  logic [SRC_W-1:0] pkt_src;
  logic             rec_done;
  ctx_rec_t         rec_d;
  ctx_rec_t         rec_q;
  logic             frame_err;
  logic             frame_abort;
  logic             rec_drop;

  ctxpkt_window_match #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .SRC_W(SRC_W)
  ) match_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_read(req_is_read),
    .req_src(req_src), .req_addr(req_addr),
    .pkt_v(pkt_v), .pkt(pkt), .pkt_src(pkt_src)
  );

  ctxpkt_framer #(
    .NUM_CORES(NUM_CORES), .SRC_W(SRC_W)
  ) framer_i (
    .clk(clk), .rst(rst), .pkt_v(pkt_v), .pkt(pkt), .pkt_src(pkt_src),
    .rec_done(rec_done), .rec_d(rec_d),
    .frame_err(frame_err), .frame_abort(frame_abort)
  );

  ctxpkt_out_reg out_i (
    .clk(clk), .rst(rst), .load(rec_done), .load_rec(rec_d),
    .ready(rec_ready), .valid(rec_valid), .rec(rec_q), .drop(rec_drop)
  );

  ctxpkt_event_ctr #(.W(CNT_W)) err_ctr_i (
    .clk(clk), .rst(rst), .inc(frame_err), .count(err_count)
  );
  ctxpkt_event_ctr #(.W(CNT_W)) abort_ctr_i (
    .clk(clk), .rst(rst), .inc(frame_abort), .count(abort_count)
  );
  ctxpkt_event_ctr #(.W(CNT_W)) ovf_ctr_i (
    .clk(clk), .rst(rst), .inc(rec_drop), .count(ovf_count)
  );

  assign rec_core = rec_q.core;
  assign rec_func = rec_q.func;
  assign rec_iter = rec_q.iter;
endmodule

// File: rtl/ctxpkt_decoder_chk.sv
module ctxpkt_decoder_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_is_read,
  input logic             pkt_v,
  input logic             rec_ready,
  input logic             rec_valid,
  input logic [11:0]      rec_core,
  input logic [15:0]      rec_func,
  input logic [15:0]      rec_iter,
  input logic [CNT_W-1:0] err_count,
  input logic [CNT_W-1:0] ovf_count
);
  // R8
  rec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_core) && $stable(rec_func) && $stable(rec_iter));

  // R4
  write_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_is_read |=> !pkt_v);

  // R3
  rec_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rec_valid) |-> $past(pkt_v));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    !(rec_valid && !rec_ready) |=> ovf_count == $past(ovf_count));

  // R5
  err_step_chk: assert property (@(posedge clk) disable iff (rst)
    !pkt_v |=> err_count == $past(err_count));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !rec_valid && (err_count == '0) && (ovf_count == '0));
endmodule

bind ctxpkt_decoder ctxpkt_decoder_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_read(req_is_read),
  .pkt_v(pkt_v), .rec_ready(rec_ready), .rec_valid(rec_valid),
  .rec_core(rec_core), .rec_func(rec_func), .rec_iter(rec_iter),
  .err_count(err_count), .ovf_count(ovf_count)
);

// File: tb/ctxpkt_decoder_tb_top.sv
module ctxpkt_decoder_tb_top;
  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam int NV = 4;
  // {src[1:0], core[11:0], func[15:0], iter[15:0]}
  localparam logic [45:0] VECS [NV] = '{
    {2'd0, 12'h012, 16'h1111, 16'h2222},
    {2'd1, 12'hABC, 16'h0000, 16'hFFFF},
    {2'd2, 12'h000, 16'hFFFF, 16'h0001},
    {2'd3, 12'hFFF, 16'h5A5A, 16'h0C00}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_is_read = 1'b0;
  logic [1:0]  req_src = '0;
  logic [31:0] req_addr = '0;
  logic        rec_ready = 1'b0;
  logic        rec_valid;
  logic [11:0] rec_core;
  logic [15:0] rec_func;
  logic [15:0] rec_iter;
  logic [15:0] err_count;
  logic [15:0] abort_count;
  logic [15:0] ovf_count;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ctxpkt_decoder dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_read(req_is_read),
    .req_src(req_src), .req_addr(req_addr), .rec_ready(rec_ready),
    .rec_valid(rec_valid), .rec_core(rec_core), .rec_func(rec_func),
    .rec_iter(rec_iter), .err_count(err_count), .abort_count(abort_count),
    .ovf_count(ovf_count)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] addr_of(logic [15:0] p);
    return BASE | (32'(p) << 6) | 32'h0000_002C;
  endfunction

  task automatic issue(logic rd, logic [1:0] src, logic [31:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_is_read = rd; req_src = src; req_addr = a;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  task automatic send_pkt(logic [1:0] src, logic [15:0] p);
    issue(1'b1, src, addr_of(p));
  endtask

  task automatic send_msg(logic [1:0] src, logic [11:0] c, logic [15:0] f, logic [15:0] it);
    send_pkt(src, {4'hC, c});
    send_pkt(src, f);
    send_pkt(src, it);
  endtask

  task automatic consume();
    @(negedge clk);
    req_valid = 1'b0; rec_ready = 1'b1;
    @(negedge clk);
    rec_ready = 1'b0;
  endtask

  task automatic chk_rec(string req, logic [11:0] c, logic [15:0] f, logic [15:0] it);
    chk(req, "rec_valid", 64'(rec_valid), 64'd1);
    chk(req, "rec_core", 64'(rec_core), 64'(c));
    chk(req, "rec_func", 64'(rec_func), 64'(f));
    chk(req, "rec_iter", 64'(rec_iter), 64'(it));
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10", "rec_valid", 64'(rec_valid), 64'd0);
    chk("R10", "err_count", 64'(err_count), 64'd0);
    chk("R10", "abort_count", 64'(abort_count), 64'd0);
    chk("R10", "ovf_count", 64'(ovf_count), 64'd0);

    // R1 R2 R3: table walk, including top line of the window (iter FFFF)
    for (int i = 0; i < NV; i++) begin
      send_msg(VECS[i][45:44], VECS[i][43:32], VECS[i][31:16], VECS[i][15:0]);
      idle(2);
      chk_rec("R3", VECS[i][43:32], VECS[i][31:16], VECS[i][15:0]);
      consume();
      chk("R8", "rec_valid after consume", 64'(rec_valid), 64'd0);
    end

    // R1: message just above and just below the window is ignored
    issue(1'b1, 2'd0, addr_of(16'hC123) ^ 32'h0040_0000);
    issue(1'b1, 2'd0, addr_of(16'h0001) ^ 32'h0040_0000);
    issue(1'b1, 2'd0, addr_of(16'h0002) ^ 32'h0040_0000);
    issue(1'b1, 2'd1, addr_of(16'hC123) - 32'h0040_0000);
    issue(1'b1, 2'd1, addr_of(16'h0001) - 32'h0040_0000);
    issue(1'b1, 2'd1, addr_of(16'h0002) - 32'h0040_0000);
    idle(2);
    chk("R1", "rec_valid out of window", 64'(rec_valid), 64'd0);
    chk("R1", "err_count out of window", 64'(err_count), 64'd0);

    // R4: writes ignored; later bare reads must count as errors (R5)
    issue(1'b0, 2'd2, addr_of(16'hC055));
    issue(1'b0, 2'd2, addr_of(16'h1234));
    issue(1'b0, 2'd2, addr_of(16'h5678));
    issue(1'b0, 2'd2, addr_of(16'hC077));
    idle(2);
    chk("R4", "rec_valid after writes", 64'(rec_valid), 64'd0);
    chk("R4", "err_count after writes", 64'(err_count), 64'd0);
    send_pkt(2'd2, 16'h1234);
    send_pkt(2'd2, 16'h5678);
    idle(2);
    chk("R4", "no record from write header", 64'(rec_valid), 64'd0);
    chk("R5", "err_count stray payloads", 64'(err_count), 64'd2);
    chk("R4", "abort_count after writes", 64'(abort_count), 64'd0);

    // R2: low address bits have no effect
    issue(1'b1, 2'd3, addr_of(16'hC00F) | 32'h3F);
    issue(1'b1, 2'd3, addr_of(16'h4321) & ~32'h3F);
    issue(1'b1, 2'd3, addr_of(16'h8765) | 32'h01);
    idle(2);
    chk_rec("R2", 12'h00F, 16'h4321, 16'h8765);
    consume();

    // R6: abort restarts from the new header
    send_pkt(2'd1, 16'hC0AA);
    send_pkt(2'd1, 16'h1111);
    send_msg(2'd1, 12'h0BB, 16'h2222, 16'h3333);
    idle(2);
    chk("R6", "abort_count", 64'(abort_count), 64'd1);
    chk_rec("R6", 12'h0BB, 16'h2222, 16'h3333);
    consume();

    // R7: interleaved sources
    send_pkt(2'd0, 16'hC0A1);
    send_pkt(2'd2, 16'hC0B2);
    send_pkt(2'd0, 16'hAAAA);
    send_pkt(2'd2, 16'hBBBB);
    send_pkt(2'd2, 16'h2222);
    idle(2);
    chk_rec("R7", 12'h0B2, 16'hBBBB, 16'h2222);
    consume();
    send_pkt(2'd0, 16'h1111);
    idle(2);
    chk_rec("R7", 12'h0A1, 16'hAAAA, 16'h1111);
    consume();
    chk("R7", "abort_count unchanged", 64'(abort_count), 64'd1);
    chk("R7", "err_count unchanged", 64'(err_count), 64'd2);

    // R9 and R8: overflow drops the new record, holds the old one
    send_msg(2'd3, 12'h333, 16'h3030, 16'h0303);
    idle(2);
    chk_rec("R8", 12'h333, 16'h3030, 16'h0303);
    send_msg(2'd1, 12'h111, 16'h1010, 16'h0101);
    idle(3);
    chk("R9", "ovf_count", 64'(ovf_count), 64'd1);
    chk_rec("R9", 12'h333, 16'h3030, 16'h0303);
    consume();
    chk("R9", "rec_valid after consume", 64'(rec_valid), 64'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule